// File: doc/BRIEF.md
# Complementary Dead-Time Gate Pulse Generator

This block drives the two switches of a half-bridge with a pair of complementary gate signals. A switching cycle is two halves of equal length. The low-side half comes first, then the high-side half. Each half opens with a dead time in which both gates are low. The gate that belongs to that half is then high for the rest of the half. The half length and the dead time are both counts of the system clock. At a 100 MHz clock, one count is 10 ns.

The frequency controller supplies the half-period. A small code selects the dead time. The lowest code stands for a shorted setting and the highest code for an open setting, and each of these maps to a fixed floor or ceiling value. Codes in between map onto the normal range.

Switching is gated by a run enable and by a two-threshold skip latch. The latch is fed by two synchronous comparator flags: "level below the lower threshold" and "level above the upper threshold". A strobe marks the first clock of every cycle.

Top module: `halfbridge_deadtime_gen`

## Requirements
- R1: After reset both gates and the strobe are low. The skip latch starts in the stopped state, so nothing switches until the upper-threshold flag has been seen.
- R2: Within one cycle of half length H and dead time D, the order is: D clocks with both gates low, then H-D clocks with only the low-side gate high, then D clocks with both low, then H-D clocks with only the high-side gate high. The two gates are never high in the same clock.
- R3: The dead-time code maps to a dead time as follows. Code 0 gives 5 clocks. Code 63 gives 100 clocks. Codes 1 to 62 give the code value clamped to the range 15 to 60 clocks. The result never decreases as the code rises.
- R4: The half-period and the dead-time code are sampled only on the clock that starts a cycle. A change in the middle of a cycle takes effect from the next cycle.
- R5: When the requested half-period is not larger than the dead time D, the half length used is D+1. Each gate then stays high for one clock per half.
- R6: The skip latch stops switching when the lower flag is set, and it also stops switching when both flags are set. It resumes when only the upper flag is set. With neither flag set it keeps its state.
- R7: Both gates are low from the first clock edge after run_en is sampled low. They are low from the second clock edge after the lower flag is sampled high.
- R8: A restart always begins a fresh cycle. The strobe rises together with a full dead time, and the low-side half comes first. The strobe appears at the first edge after run_en returns. When the restart comes from the upper flag, the strobe appears at the second edge after that flag.
- R9: cyc_start is high for exactly one clock, on the first clock of each low-side half. Consecutive strobes are 2H clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one count of every timing value |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Switching permitted when high |
| half_per | input | 13 | Requested half-period in clocks |
| dt_code | input | 6 | Dead-time code (0 = shorted, 63 = open) |
| ctl_above_hi | input | 1 | Control level above the upper threshold |
| ctl_below_lo | input | 1 | Control level below the lower threshold |
| gate_hi | output | 1 | High-side gate command |
| gate_lo | output | 1 | Low-side gate command |
| cyc_start | output | 1 | One-clock strobe at the start of each cycle |

## Verification
The gate outputs are decoded from registered state, so each response has a fixed latency:
- A low run_en clears the gates one edge later.
- A lower-flag sample clears them two edges later.
- A resume strobe follows one edge after run_en returns, or two edges after the upper flag.
- New half-period and dead-time values appear only at the next strobe.

The bench drives inputs and samples outputs on the falling clock edge. It checks the still-high gate exactly one sample after a skip request and the cleared gates at the following sample. It measures the four segment lengths of each cycle sample by sample, starting from a strobe. Mid-cycle changes are applied a known number of samples after a strobe, so the cycle in progress and the next one are each checked against their own expected values.

// File: rtl/hbdt_pkg.sv
// Shared types for the half-bridge dead-time pulse generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package hbdt_pkg;
    // Which half of the switching cycle the sequencer is in
    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_e;
endpackage

// File: rtl/hbdt_dead_map.sv
// Maps the dead-time code to a dead time in clocks.
// The lowest code is a shorted setting (floor value) and the highest code is
// an open setting (ceiling value). All other codes are clamped into the
// normal range.
// Assumes DT_MIN..DT_MAX fit in the code width and DT_OPEN fits in DT_W bits.
module hbdt_dead_map #(
    parameter int DTC_W    = 6,
    parameter int DT_W     = 7,
    parameter int DT_SHORT = 5,
    parameter int DT_OPEN  = 100,
    parameter int DT_MIN   = 15,
    parameter int DT_MAX   = 60
) (
    input  logic [DTC_W-1:0] code,
    output logic [DT_W-1:0]  dead_cyc
);
    localparam logic [DTC_W-1:0] CODE_SHORT = '0;
    localparam logic [DTC_W-1:0] CODE_OPEN  = '1;
    localparam logic [DTC_W-1:0] CODE_LO    = DTC_W'(DT_MIN);
    localparam logic [DTC_W-1:0] CODE_HI    = DTC_W'(DT_MAX);
    localparam logic [DT_W-1:0]  V_SHORT    = DT_W'(DT_SHORT);
    localparam logic [DT_W-1:0]  V_OPEN     = DT_W'(DT_OPEN);
    localparam logic [DT_W-1:0]  V_MIN      = DT_W'(DT_MIN);
    localparam logic [DT_W-1:0]  V_MAX      = DT_W'(DT_MAX);

    // Select floor/ceiling for the abnormal codes, clamp the rest
    always_comb begin
        if (code == CODE_SHORT) begin
            dead_cyc = V_SHORT;
        end else if (code == CODE_OPEN) begin
            dead_cyc = V_OPEN;
        end else if (code < CODE_LO) begin
            dead_cyc = V_MIN;
        end else if (code > CODE_HI) begin
            dead_cyc = V_MAX;
        end else begin
            dead_cyc = DT_W'(code);
        end
    end
endmodule

// File: rtl/hbdt_skip_latch.sv
// Two-threshold skip hysteresis.
// The lower flag stops switching and wins if both flags are set. The upper
// flag alone resumes switching. With neither flag set, the state is held.
// Assumes both flags are clean and synchronous to clk.
// Leaves reset in the stopped state.
module hbdt_skip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic below_lo,
    input  logic above_hi,
    output logic halted
);
    // Hysteresis state: set by the lower flag, cleared by the upper flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b1;
        end else if (below_lo) begin
            halted <= 1'b1;
        end else if (above_hi) begin
            halted <= 1'b0;
        end
    end
endmodule

// File: rtl/hbdt_half_seq.sv
// Half-cycle sequencer.
// It counts each half of the cycle, latches the half-period and dead time at
// the start of every cycle, and decodes the two gates and the cycle strobe
// from its registers. When run is low it returns to idle, so the next start
// is a fresh low-side half.
// Assumes HP_W >= DT_W and a dead time of at least one clock.
module hbdt_half_seq
    import hbdt_pkg::*;
#(
    parameter int HP_W = 13,
    parameter int DT_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [HP_W-1:0] half_req,
    input  logic [DT_W-1:0] dead_req,
    output logic            gate_hi,
    output logic            gate_lo,
    output logic            cyc_start
);
    localparam logic [HP_W-1:0] ONE = HP_W'(1);

    logic [HP_W-1:0] dead_ext;
    logic [HP_W-1:0] half_eff;
    logic            active;
    half_e           side;
    logic [HP_W-1:0] cnt;
    logic [HP_W-1:0] half_lat;
    logic [HP_W-1:0] dead_lat;
    logic            at_end;
    logic            past_dead;

    assign dead_ext = HP_W'(dead_req);

    // Stretch a half-period that leaves no on-time to dead time plus one
    always_comb begin
        if (half_req > dead_ext) begin
            half_eff = half_req;
        end else begin
            half_eff = dead_ext + ONE;
        end
    end

    assign at_end    = (cnt == (half_lat - ONE));
    assign past_dead = (cnt >= dead_lat);

    // Cycle/half counter with cycle-boundary loading of period and dead time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            side     <= HALF_LOW;
            cnt      <= '0;
            half_lat <= '0;
            dead_lat <= '0;
        end else if (!run) begin
            active <= 1'b0;
            side   <= HALF_LOW;
            cnt    <= '0;
        end else if (!active || (side == HALF_HIGH && at_end)) begin
            active   <= 1'b1;
            side     <= HALF_LOW;
            cnt      <= '0;
            half_lat <= half_eff;
            dead_lat <= dead_ext;
        end else if (at_end) begin
            side <= HALF_HIGH;
            cnt  <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // Gate and strobe decode from registered state only
    always_comb begin
        gate_lo   = active && (side == HALF_LOW)  && past_dead;
        gate_hi   = active && (side == HALF_HIGH) && past_dead;
        cyc_start = active && (side == HALF_LOW)  && (cnt == '0);
    end
endmodule

// File: rtl/halfbridge_deadtime_gen.sv
// Complementary dead-time gate pulse generator, top level.
// It combines the dead-time code map, the skip hysteresis latch and the
// half-cycle sequencer. Switching runs while run_en is high and the skip
// latch is released.
// Assumes all inputs are synchronous to clk and that one clock is the
// timing resolution of the half-period and the dead time.
module halfbridge_deadtime_gen #(
    parameter int HP_W     = 13,
    parameter int DTC_W    = 6,
    parameter int DT_SHORT = 5,
    parameter int DT_OPEN  = 100,
    parameter int DT_MIN   = 15,
    parameter int DT_MAX   = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [HP_W-1:0]  half_per,
    input  logic [DTC_W-1:0] dt_code,
    input  logic             ctl_above_hi,
    input  logic             ctl_below_lo,
    output logic             gate_hi,
    output logic             gate_lo,
    output logic             cyc_start
);
    localparam int DT_W = $clog2(DT_OPEN + 1);

    logic [DT_W-1:0] dead_cyc;
    logic            halted;
    logic            run;

    hbdt_dead_map #(
        .DTC_W   (DTC_W),
        .DT_W    (DT_W),
        .DT_SHORT(DT_SHORT),
        .DT_OPEN (DT_OPEN),
        .DT_MIN  (DT_MIN),
        .DT_MAX  (DT_MAX)
    ) u_map (
        .code    (dt_code),
        .dead_cyc(dead_cyc)
    );

    hbdt_skip_latch u_skip (
        .clk     (clk),
        .rst_n   (rst_n),
        .below_lo(ctl_below_lo),
        .above_hi(ctl_above_hi),
        .halted  (halted)
    );

    // Switching is permitted only when enabled and not skipped
    assign run = run_en && !halted;

    hbdt_half_seq #(
        .HP_W(HP_W),
        .DT_W(DT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_req (half_per),
        .dead_req (dead_cyc),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo),
        .cyc_start(cyc_start)
    );
endmodule

// File: rtl/hbdt_checker.sv
// Protocol checks for halfbridge_deadtime_gen, attached with bind.
// Assumes a synchronous active-low reset.
module hbdt_checker (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic ctl_below_lo,
    input logic gate_hi,
    input logic gate_lo,
    input logic cyc_start
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!gate_hi && !gate_lo && !cyc_start));

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    // R2
    lo_hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_lo) |-> !gate_hi);

    // R6
    skip_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_below_lo |-> ##2 (!gate_hi && !gate_lo));

    // R7
    run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!gate_hi && !gate_lo));

    // R8
    start_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> (!gate_hi && !gate_lo));

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start);
endmodule

bind halfbridge_deadtime_gen hbdt_checker chk_u (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .ctl_below_lo(ctl_below_lo),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .cyc_start   (cyc_start)
);

// File: tb/halfbridge_deadtime_gen_test.sv
// Directed bench for halfbridge_deadtime_gen: one task per scenario.
module halfbridge_deadtime_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b1;
    logic [12:0] half_per = 13'd300;
    logic [5:0]  dt_code = 6'd8;
    logic        ctl_above_hi = 1'b0;
    logic        ctl_below_lo = 1'b0;
    logic        gate_hi;
    logic        gate_lo;
    logic        cyc_start;

    int n_checks = 0;
    int n_errors = 0;
    int overlap = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    halfbridge_deadtime_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .half_per    (half_per),
        .dt_code     (dt_code),
        .ctl_above_hi(ctl_above_hi),
        .ctl_below_lo(ctl_below_lo),
        .gate_hi     (gate_hi),
        .gate_lo     (gate_lo),
        .cyc_start   (cyc_start)
    );

    // Overlap monitor and watchdog
    always @(negedge clk) begin
        cycles++;
        if (gate_hi && gate_lo) overlap++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    function automatic int exp_dead(input int code);
        if (code == 0) return 5;
        if (code == 63) return 100;
        if (code < 15) return 15;
        if (code > 60) return 60;
        return code;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sync_start();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!cyc_start && guard < 20000);
        if (guard >= 20000) chk("R9 strobe timeout", 0, 1);
    endtask

    task automatic wait_gate(input bit hi_side);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (((hi_side ? gate_hi : gate_lo) == 1'b0) && guard < 20000);
        if (guard >= 20000) chk("R2 gate timeout", 0, 1);
    endtask

    task automatic idle_check(input int n, input string tag);
        int busy = 0;
        repeat (n) begin
            @(negedge clk);
            if (gate_hi || gate_lo || cyc_start) busy++;
        end
        chk(tag, busy, 0);
    endtask

    // Measure one cycle starting at the current (strobe) sample
    task automatic check_cycle(input string tag, input int dead, input int half);
        int d1 = 0;
        int lon = 0;
        int d2 = 0;
        int hon = 0;
        int ph = 0;
        int guard = 0;
        while (ph != 4 && guard < 20000) begin
            case (ph)
                0: if (gate_lo) begin ph = 1; lon++; end else d1++;
                1: if (gate_lo) lon++; else begin ph = 2; d2++; end
                2: if (gate_hi) begin ph = 3; hon++; end else d2++;
                default: if (gate_hi) hon++; else ph = 4;
            endcase
            if (ph != 4) begin
                @(negedge clk);
                guard++;
            end
        end
        chk({tag, " lead dead"}, d1, dead);
        chk({tag, " low on"}, lon, half - dead);
        chk({tag, " mid dead"}, d2, dead);
        chk({tag, " high on"}, hon, half - dead);
        chk({tag, " R9 next strobe"}, int'(cyc_start), 1);
    endtask

    task automatic t_reset_start();
        repeat (4) @(negedge clk);
        chk("R1 outputs in reset", int'(gate_hi | gate_lo | cyc_start), 0);
        rst_n = 1'b1;
        idle_check(100, "R1 halted until upper flag");
        ctl_above_hi = 1'b1;
        @(negedge clk);
        ctl_above_hi = 1'b0;
        @(negedge clk);
        chk("R8 first strobe", int'(cyc_start), 1);
        chk("R8 dead at first strobe", int'(gate_hi | gate_lo), 0);
        check_cycle("R2 cycle", 15, 300);
    endtask

    task automatic t_dead_codes();
        int codes[5] = '{0, 63, 1, 40, 62};
        foreach (codes[i]) begin
            dt_code = 6'(codes[i]);
            sync_start();
            check_cycle($sformatf("R3 code %0d", codes[i]), exp_dead(codes[i]), 300);
        end
    endtask

    task automatic t_boundary_latch();
        dt_code = 6'd20;
        half_per = 13'd200;
        sync_start();
        fork
            check_cycle("R4 old values", 20, 200);
            begin
                repeat (30) @(negedge clk);
                half_per = 13'd260;
                dt_code = 6'd30;
            end
        join
        check_cycle("R4 new values", 30, 260);
    endtask

    task automatic t_short_half();
        dt_code = 6'd40;
        half_per = 13'd10;
        sync_start();
        check_cycle("R5 half below dead", 40, 41);
        half_per = 13'd40;
        sync_start();
        check_cycle("R5 half equal dead", 40, 41);
        half_per = 13'd42;
        sync_start();
        check_cycle("R5 half above dead", 40, 42);
    endtask

    task automatic t_skip();
        half_per = 13'd300;
        dt_code = 6'd10;
        sync_start();
        wait_gate(1'b0);
        ctl_below_lo = 1'b1;
        @(negedge clk);
        ctl_below_lo = 1'b0;
        chk("R7 low gate held one edge", int'(gate_lo), 1);
        @(negedge clk);
        chk("R6 lower flag stops", int'(gate_hi | gate_lo), 0);
        idle_check(300, "R6 hold between thresholds");
        ctl_above_hi = 1'b1;
        @(negedge clk);
        ctl_above_hi = 1'b0;
        @(negedge clk);
        chk("R8 resume strobe", int'(cyc_start), 1);
        check_cycle("R8 resume cycle", 15, 300);
        wait_gate(1'b1);
        ctl_below_lo = 1'b1;
        ctl_above_hi = 1'b1;
        @(negedge clk);
        ctl_below_lo = 1'b0;
        ctl_above_hi = 1'b0;
        @(negedge clk);
        chk("R6 both flags stop", int'(gate_hi | gate_lo), 0);
        idle_check(100, "R6 both flags held stopped");
        ctl_above_hi = 1'b1;
        @(negedge clk);
        ctl_above_hi = 1'b0;
        @(negedge clk);
        chk("R8 second resume strobe", int'(cyc_start), 1);
    endtask

    task automatic t_run_enable();
        wait_gate(1'b1);
        run_en = 1'b0;
        @(negedge clk);
        chk("R7 run_en off", int'(gate_hi | gate_lo | cyc_start), 0);
        idle_check(50, "R7 stays off");
        run_en = 1'b1;
        @(negedge clk);
        chk("R8 restart strobe", int'(cyc_start), 1);
        chk("R8 restart dead", int'(gate_hi | gate_lo), 0);
        check_cycle("R8 restart cycle", 15, 300);
    endtask

    initial begin
        t_reset_start();
        t_dead_codes();
        t_boundary_latch();
        t_short_half();
        t_skip();
        t_run_enable();
        chk("R2 overlap samples", overlap, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule